// File: doc/BRIEF.md
# Control Register Integrity Tag Checker

This block watches the write and read traffic of a processor's privileged register file and guards a small set of mode-defining registers: five 32-bit control registers and six 16-bit segment registers. It holds no register data itself. On every write to a guarded register it computes a short keyed tag from the register number and the written value, and keeps that tag in its own tag store. On every read of a guarded register it computes the tag again from the value that the register file returns and compares it with the stored one. If the two differ, the block flags that read and raises a sticky integrity alarm. This exposes bits that flipped while the register held its value, and it also exposes a read path that delivered a wrong value.

The tag is keyed by the register number, which serves as the challenge. The key comes from a fixed device-secret parameter. In a product this parameter would be replaced by a physically unclonable source. General-purpose registers fall outside the guarded address range and are never checked. The alarm holds the number of the first register that failed, so that the exception handler can see which register was affected. Software clears the alarm with a clear strobe.

Top module: `crg_guard`

## Requirements
- R1: After reset, `alarm`, `chk_valid` and `chk_fail` are 0, `alarm_addr` is 0, and every tag entry is marked unwritten.
- R2: Addresses 0 to NUM_CTRL-1 are control registers (32 bits). Addresses NUM_CTRL to NUM_CTRL+NUM_SEG-1 are segment registers (16 bits). Every other address is unguarded. A read of an unguarded address never sets `chk_valid` or `chk_fail`. A write to an unguarded address leaves every stored tag unchanged.
- R3: The tag is computed as follows. The key is `SECRET ^ (addr * 32'h9E3779B9)`, taken modulo 2^32. The data is XORed with the key. The four bytes of that word are XORed together into a byte f. The tag is f rotated left by 3 bits, XORed with key bits [15:8].
- R4: A write with `wr_en` to a guarded address stores that address's tag. A read with `rd_en` of a guarded address sets `chk_valid` to 1 in the next cycle. In that same cycle, `chk_fail` is 1 exactly when the tag of `rd_data` differs from the stored tag.
- R5: For segment registers, bits [31:16] are replaced by zero before the tag is computed, on both writes and reads. Those bits therefore never affect a check.
- R6: A read of a guarded register that has not been written since reset gives `chk_valid`=1 and `chk_fail`=0.
- R7: If a guarded register is written and read in the same cycle, the read is compared against the tag of the value being written in that cycle.
- R8: `alarm` rises in the cycle after `chk_fail` is 1 and then stays at 1. `alarm_addr` takes the address of the failing read that raised the alarm. Later failures do not change it while the alarm is held.
- R9: `alarm_clr` drops the alarm in the next cycle and leaves `alarm_addr` as it was. If `chk_fail` is 1 in the same cycle as `alarm_clr`, the failure wins: `alarm` stays at 1 and `alarm_addr` takes the new failing address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register file write strobe |
| wr_addr | input | ADDR_W | Register number being written |
| wr_data | input | 32 | Value being written |
| rd_en | input | 1 | Register file read strobe |
| rd_addr | input | ADDR_W | Register number being read |
| rd_data | input | 32 | Value returned by the register file in the read cycle |
| alarm_clr | input | 1 | Clears the sticky alarm |
| chk_valid | output | 1 | A guarded read was checked in the previous cycle |
| chk_fail | output | 1 | That check found a tag mismatch |
| alarm | output | 1 | Sticky integrity alarm |
| alarm_addr | output | ADDR_W | Register number of the failure that raised the alarm |

## Verification
The bench uses the default build: NUM_CTRL=5, NUM_SEG=6, ADDR_W=4 and a fixed SECRET. With these values, addresses 11 to 15 are unguarded and sit in the same address space as the guarded ones, so decode aliasing can be tested. Segment entries can be given upper-half bits that differ between the write and the read. Because the bench knows the key, it can build a two-bit corruption whose byte fold cancels and still leaves the tag unchanged. The per-cycle reference model also covers a same-cycle write and read, a failure that coincides with a clear, and a long mixed run of random traffic with occasional corrupted read data.

// File: rtl/crg_pkg.sv
package crg_pkg;

  localparam int DATA_W = 32;
  localparam int SEG_W  = 16;
  localparam int TAG_W  = 8;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_CTRL = 2'd1,
    RC_SEG  = 2'd2
  } reg_class_e;

  // Keyed tag: per-address key, byte fold, one rotate-and-XOR round.
  function automatic logic [TAG_W-1:0] tag_fn(input logic [DATA_W-1:0] secret,
                                              input logic [7:0]        addr,
                                              input logic [DATA_W-1:0] data);
    logic [DATA_W-1:0] key;
    logic [DATA_W-1:0] mixed;
    logic [TAG_W-1:0]  fold;
    key   = secret ^ ({24'd0, addr} * 32'h9E3779B9);
    mixed = data ^ key;
    fold  = mixed[7:0] ^ mixed[15:8] ^ mixed[23:16] ^ mixed[31:24];
    return {fold[4:0], fold[7:5]} ^ key[15:8];
  endfunction

  function automatic logic [DATA_W-1:0] narrow_fn(input reg_class_e cls,
                                                 input logic [DATA_W-1:0] data);
    return (cls == RC_SEG) ? {{(DATA_W-SEG_W){1'b0}}, data[SEG_W-1:0]} : data;
  endfunction

endpackage

// File: rtl/crg_classify.sv
module crg_classify
  import crg_pkg::*;
#(
  parameter int NUM_CTRL = 5,
  parameter int NUM_SEG  = 6,
  parameter int ADDR_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_class_e        cls
);
  localparam int ENTRIES = NUM_CTRL + NUM_SEG;

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    if (a32 < 32'(NUM_CTRL))     cls = RC_CTRL;
    else if (a32 < 32'(ENTRIES)) cls = RC_SEG;
    else                         cls = RC_NONE;
  end
endmodule

// File: rtl/crg_tag_store.sv
module crg_tag_store
  import crg_pkg::*;
#(
  parameter int ENTRIES = 11,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rvalid,
  output logic [TAG_W-1:0]  rtag
);
  logic [ENTRIES-1:0] valid_vec;
  logic [TAG_W-1:0]   tag_arr [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic             v;
    logic [TAG_W-1:0] t;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v <= 1'b0;
        t <= '0;
      end else if (we && (32'(waddr) == 32'(i))) begin
        v <= 1'b1;
        t <= wtag;
      end
    end
    assign valid_vec[i] = v;
    assign tag_arr[i]   = t;
  end

  always_comb begin
    rvalid = 1'b0;
    rtag   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (32'(raddr) == 32'(i)) begin
        rvalid = valid_vec[i];
        rtag   = tag_arr[i];
      end
    end
  end

  // R4 / R2: stored state only moves on an accepted write
  assert_store_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(valid_vec));
  // R1: nothing is valid coming out of reset without a write
  assert_valid_needs_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec != $past(valid_vec)) |-> $past(we));
endmodule

// File: rtl/crg_alarm.sv
module crg_alarm #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic              clr,
  output logic              alarm,
  output logic [ADDR_W-1:0] alarm_addr
);
  logic capture;
  assign capture = fail && (!alarm || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm      <= 1'b0;
      alarm_addr <= '0;
    end else if (capture) begin
      alarm      <= 1'b1;
      alarm_addr <= fail_addr;
    end else if (clr) begin
      alarm      <= 1'b0;
    end
  end

  assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> alarm);
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> $stable(alarm_addr));
  assert_alarm_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(fail));
  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fail) |=> !alarm);
  assert_fail_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && fail) |=> alarm);
endmodule

// File: rtl/crg_guard.sv
module crg_guard
  import crg_pkg::*;
#(
  parameter int          NUM_CTRL = 5,
  parameter int          NUM_SEG  = 6,
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] SECRET   = 32'h5A3C_96E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  input  logic              alarm_clr,
  output logic              chk_valid,
  output logic              chk_fail,
  output logic              alarm,
  output logic [ADDR_W-1:0] alarm_addr
);
  localparam int ENTRIES = NUM_CTRL + NUM_SEG;

  reg_class_e        wr_cls, rd_cls;
  logic              wr_prot, rd_prot;
  logic [TAG_W-1:0]  wr_tag, rd_tag, st_tag, ref_tag;
  logic              st_valid, ref_valid, bypass;
  logic [ADDR_W-1:0] chk_addr_q;

  crg_classify #(.NUM_CTRL(NUM_CTRL), .NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W))
    u_wcls (.addr(wr_addr), .cls(wr_cls));
  crg_classify #(.NUM_CTRL(NUM_CTRL), .NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W))
    u_rcls (.addr(rd_addr), .cls(rd_cls));

  assign wr_prot = (wr_cls != RC_NONE);
  assign rd_prot = (rd_cls != RC_NONE);
  assign wr_tag  = tag_fn(SECRET, 8'(wr_addr), narrow_fn(wr_cls, wr_data));
  assign rd_tag  = tag_fn(SECRET, 8'(rd_addr), narrow_fn(rd_cls, rd_data));

  crg_tag_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && wr_prot), .waddr(wr_addr), .wtag(wr_tag),
    .raddr(rd_addr), .rvalid(st_valid), .rtag(st_tag)
  );

  // Same-cycle write forwarding, matching the register file bypass
  assign bypass    = wr_en && wr_prot && (wr_addr == rd_addr);
  assign ref_valid = bypass || st_valid;
  assign ref_tag   = bypass ? wr_tag : st_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid  <= 1'b0;
      chk_fail   <= 1'b0;
      chk_addr_q <= '0;
    end else begin
      chk_valid  <= rd_en && rd_prot;
      chk_fail   <= rd_en && rd_prot && ref_valid && (ref_tag != rd_tag);
      chk_addr_q <= rd_addr;
    end
  end

  crg_alarm #(.ADDR_W(ADDR_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .fail(chk_fail), .fail_addr(chk_addr_q),
    .clr(alarm_clr), .alarm(alarm), .alarm_addr(alarm_addr)
  );

  assert_fail_has_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |-> chk_valid);
  assert_check_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $past(rd_en));
  assert_unguarded_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_prot) |=> !chk_valid);
  assert_unwritten_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ref_valid) |=> !chk_fail);
  assert_bypass_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bypass && (wr_tag == rd_tag)) |=> !chk_fail);
endmodule

// File: tb/sim_crg_guard.sv
module sim_crg_guard;
  localparam int          CLK_P  = 10;
  localparam int          NC     = 5;
  localparam int          NS     = 6;
  localparam logic [31:0] SECRET = 32'h5A3C_96E1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, alarm_clr = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data = '0;
  logic       chk_valid, chk_fail, alarm;
  logic [3:0] alarm_addr;

  int n_checks = 0;
  int n_err    = 0;

  crg_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .alarm_clr(alarm_clr),
    .chk_valid(chk_valid), .chk_fail(chk_fail), .alarm(alarm), .alarm_addr(alarm_addr)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit guarded(int a);
    return a < NC + NS;
  endfunction

  function automatic bit [31:0] eff(int a, bit [31:0] d);
    return (a >= NC && a < NC + NS) ? (d & 32'h0000_FFFF) : d;
  endfunction

  function automatic bit [7:0] btag(int a, bit [31:0] d);
    bit [31:0] k, m;
    bit [7:0]  f;
    k = SECRET ^ (32'(a) * 32'h9E3779B9);
    m = eff(a, d) ^ k;
    f = 8'h00;
    for (int b = 0; b < 4; b++) f = f ^ m[8*b +: 8];
    return 8'((f << 3) | (f >> 5)) ^ k[15:8];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, advanced on each rising edge, compared shortly after
  bit       m_valid [16];
  bit [7:0] m_tag   [16];
  bit       m_cv, m_cf, m_alarm;
  int       m_caddr, m_aaddr;

  always @(posedge clk) begin
    bit rv, nv, nf;
    bit [7:0] rt;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_valid[i] = 1'b0; m_tag[i] = 8'h00; end
      m_cv = 0; m_cf = 0; m_alarm = 0; m_caddr = 0; m_aaddr = 0;
    end else begin
      if (m_cf && (!m_alarm || alarm_clr)) begin m_alarm = 1; m_aaddr = m_caddr; end
      else if (alarm_clr) m_alarm = 0;
      nv = rd_en && guarded(int'(rd_addr));
      if (wr_en && guarded(int'(wr_addr)) && wr_addr == rd_addr) begin
        rv = 1; rt = btag(int'(wr_addr), wr_data);
      end else begin
        rv = m_valid[rd_addr]; rt = m_tag[rd_addr];
      end
      nf = nv && rv && (rt != btag(int'(rd_addr), rd_data));
      if (wr_en && guarded(int'(wr_addr))) begin
        m_valid[wr_addr] = 1; m_tag[wr_addr] = btag(int'(wr_addr), wr_data);
      end
      m_cv = nv; m_cf = nf; m_caddr = int'(rd_addr);
    end
    #(CLK_P/5);
    chk(chk_valid == m_cv, "R4 chk_valid", 32'(chk_valid), 32'(m_cv));
    chk(chk_fail == m_cf, "R4 chk_fail", 32'(chk_fail), 32'(m_cf));
    chk(alarm == m_alarm, "R8 alarm", 32'(alarm), 32'(m_alarm));
    chk(int'(alarm_addr) == m_aaddr, "R8 alarm_addr", 32'(alarm_addr), 32'(m_aaddr));
  end

  task automatic op(bit we, int wa, bit [31:0] wd, bit re, int ra, bit [31:0] rd, bit cl);
    wr_en = we; wr_addr = 4'(wa); wr_data = wd;
    rd_en = re; rd_addr = 4'(ra); rd_data = rd; alarm_clr = cl;
    @(negedge clk);
    wr_en = 0; rd_en = 0; alarm_clr = 0;
  endtask

  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0);
  endtask

  bit [31:0] sh [16];

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog R4 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(!alarm, "R1 alarm", 32'(alarm), 0);
    chk(!chk_valid && !chk_fail, "R1 chk", {chk_valid, chk_fail}, 0);
    chk(alarm_addr == 0, "R1 alarm_addr", 32'(alarm_addr), 0);

    // R6 unwritten guarded read
    op(0, 0, 0, 1, 3, 32'hDEAD_BEEF, 0);
    chk(chk_valid && !chk_fail, "R6 unwritten read", {chk_valid, chk_fail}, 32'h2);

    for (int i = 0; i < 16; i++) begin
      sh[i] = 32'hABCD_0000 ^ (32'(i) * 32'h0101_1357);
      op(1, i, sh[i], 0, 0, 0, 0);
    end

    // R4 clean read
    op(0, 0, 0, 1, 2, sh[2], 0);
    chk(chk_valid && !chk_fail, "R4 clean read", {chk_valid, chk_fail}, 32'h2);
    // R3 two flips in one fold column cancel
    op(0, 0, 0, 1, 2, sh[2] ^ 32'h0000_0101, 0);
    chk(!chk_fail, "R3 fold cancel", 32'(chk_fail), 0);
    // R2 unguarded address not checked, writes there harmless
    op(0, 0, 0, 1, 13, 32'h1234_5678, 0);
    chk(!chk_valid, "R2 unguarded read", 32'(chk_valid), 0);
    op(1, 12, 32'hFFFF_FFFF, 0, 0, 0, 0);
    op(0, 0, 0, 1, 1, sh[1], 0);
    chk(chk_valid && !chk_fail, "R2 guarded after unguarded write", {chk_valid, chk_fail}, 32'h2);
    // R5 segment upper half ignored
    op(0, 0, 0, 1, 7, sh[7] ^ 32'h5A5A_0000, 0);
    chk(chk_valid && !chk_fail, "R5 seg upper ignored", {chk_valid, chk_fail}, 32'h2);
    // R8 first failure latched
    op(0, 0, 0, 1, 7, sh[7] ^ 32'h0000_0001, 0);
    chk(chk_fail, "R4 seg low flip", 32'(chk_fail), 1);
    idle();
    chk(alarm && alarm_addr == 7, "R8 first failure", {alarm, 28'(alarm_addr)}, 32'h1000_0007);
    op(0, 0, 0, 1, 1, sh[1] ^ 32'h0010_0000, 0);
    idle();
    chk(alarm && alarm_addr == 7, "R8 address held", {alarm, 28'(alarm_addr)}, 32'h1000_0007);
    // R9 plain clear
    op(0, 0, 0, 0, 0, 0, 1);
    chk(!alarm && alarm_addr == 7, "R9 clear", {alarm, 28'(alarm_addr)}, 32'h0000_0007);
    // R9 failure coincident with clear wins
    op(0, 0, 0, 1, 4, sh[4] ^ 32'h8000_0000, 0);
    idle();
    op(0, 0, 0, 1, 6, sh[6] ^ 32'h0000_0100, 0);
    op(0, 0, 0, 0, 0, 0, 1);
    chk(alarm && alarm_addr == 6, "R9 fail beats clear", {alarm, 28'(alarm_addr)}, 32'h1000_0006);
    op(0, 0, 0, 0, 0, 0, 1);
    // R7 same-cycle write and read
    sh[3] = 32'h0BAD_F00D;
    op(1, 3, sh[3], 1, 3, sh[3], 0);
    chk(chk_valid && !chk_fail, "R7 bypass new value", {chk_valid, chk_fail}, 32'h2);
    op(1, 0, 32'h7777_0000, 1, 0, sh[0], 0);
    sh[0] = 32'h7777_0000;
    chk(chk_fail, "R7 stale value flagged", 32'(chk_fail), 1);
    op(0, 0, 0, 1, 3, sh[3], 0);
    chk(!chk_fail, "R7 stored after bypass", 32'(chk_fail), 0);
    op(0, 0, 0, 0, 0, 0, 1);

    // Mixed random traffic, compared against the model each cycle
    for (int n = 0; n < 400; n++) begin
      int wa, ra;
      bit we, re, cl;
      bit [31:0] wd, rd;
      wa = int'($urandom_range(15)); ra = int'($urandom_range(15));
      we = ($urandom_range(3) == 0); re = ($urandom_range(1) == 0);
      cl = ($urandom_range(15) == 0);
      wd = $urandom;
      rd = (we && wa == ra) ? wd : sh[ra];
      if ($urandom_range(9) == 0) rd = rd ^ (32'h1 << $urandom_range(31));
      if (we) sh[wa] = wd;
      op(we, wa, wd, re, ra, rd, cl);
    end
    repeat (3) idle();

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule